// File: doc/BRIEF.md
# Multi-Lane SPI Flash Shifter

This block is the master side of a serial flash link that can widen its data path. Every transaction opens with a command byte shifted out on a single line. After the command, the chosen lane width applies to the address bytes and the data bytes. The data path can be one bit wide (separate out and in lines), two bits wide or four bits wide. The two- and four-bit widths are half duplex over shared I/O pins, and the four-bit width also borrows the write-protect and hold pins.

A host starts a transaction by holding the command, the lane width, the address byte count, the dummy clock count, the data byte count and the direction on the inputs, then raising `start` for one cycle. Address and write bytes are pulled from a transmit stream through `txTake`. Received bytes come out on `rxData` with a one-cycle `rxValid` strobe. The bus runs with clock idle low: data changes on the falling SCLK edge and is sampled on the rising edge. Each SCLK half period lasts `HALF_DIV` system clocks. The phases run in a fixed order: command, address, dummy clocks, data. Any phase with a zero count is skipped.

Top module: `mlane_spi_shifter`

## Requirements
- R1: Out of reset and between transactions, `csN` is 1, `sclk` is 0, `ioOe` is 0000, and `done` and `busy` are 0.
- R2: The command byte is always sent on IO0, most significant bit first, over 8 SCLK periods, whatever the lane width. During the command, IO1 is not driven.
- R3: Address and write bytes follow `laneMode`. With 0, one bit per clock goes on IO0. With 1, two bits per clock: bit 7 on IO1 and bit 6 on IO0 first. With 2 or 3, four bits per clock: bits 7..4 on IO3..IO0 first. The most significant group always goes first.
- R4: Read bytes are sampled on rising SCLK edges, most significant group first. In single mode the bit comes from IO1, in dual mode from IO1:IO0, and in quad mode from IO3:IO0. Each finished byte appears on `rxData` with a one-cycle `rxValid` pulse.
- R5: After the command, the address phase takes addrBytes·8/w SCLK periods, the dummy phase takes `dummyClocks` periods and the data phase takes dataBytes·8/w periods, where w is the lane width. All data lanes are released during the dummy clocks.
- R6: The data-lane output enables drop at the falling SCLK edge that ends the last driven bit. They stay low through the dummy, read and closing phases. In quad mode, IO2 and IO3 are released as well.
- R7: In single and dual mode, IO2 and IO3 are enabled and driven to 1 for the whole transaction. In quad mode, this holds during the command phase.
- R8: `csN` falls on the clock edge that accepts `start`. It stays low for the whole transaction and rises one half period after the last falling SCLK edge. `done` is high for exactly that one cycle.
- R9: `sclk` is 0 whenever `csN` is 1. Every SCLK level, including the gap from `csN` falling to the first rising edge, lasts exactly `HALF_DIV` clocks.
- R10: `txTake` pulses once for each address byte and each write byte, in stream order, in the cycle that byte is loaded. It does not pulse for read bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (accepted while idle) |
| cmdByte | input | 8 | Command byte |
| laneMode | input | 2 | 0 single, 1 dual, 2 or 3 quad |
| addrBytes | input | ADDR_W | Number of address bytes |
| dummyClocks | input | DUMMY_W | Number of dummy SCLK periods |
| dataBytes | input | DATA_W | Number of data bytes |
| isRead | input | 1 | 1 = data phase receives, 0 = transmits |
| txData | input | 8 | Head of transmit stream |
| txTake | output | 1 | Head of stream consumed this cycle |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | `rxData` updated this cycle |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| csN | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| ioOut | output | 4 | Values for IO3..IO0 |
| ioOe | output | 4 | Output enables for IO3..IO0 |
| ioIn | input | 4 | Sampled levels of IO3..IO0 |

## Verification
A wrong beat or unit counter shows up at the ports as a bad SCLK total at `done`. It also shows up within one SCLK period as an output enable that is wrong for the phase the bench expects. A lane-width or bit-order fault makes a driven group mismatch at the very next rising edge. A fault in the receive shift gives a wrong `rxData` at the end of the first read byte. The bench tracks the phase only from the SCLK edges it sees, and it compares enables, the held-high pins and the half-period spacing on every clock.

// File: rtl/mlaneSpiPkg.sv
package mlaneSpiPkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_TAIL
  } phase_e;

  typedef enum logic [1:0] {
    LW_ONE  = 2'd0,
    LW_TWO  = 2'd1,
    LW_FOUR = 2'd2
  } lane_e;

  typedef struct packed {
    logic  loadCmd;
    logic  loadTx;
    logic  sample;
    logic  shift;
    logic  rxPush;
    lane_e width;
  } strobe_t;
endpackage

// File: rtl/mlane_spi_ctrl.sv
module mlane_spi_ctrl
  import mlaneSpiPkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 3,
  parameter int DUMMY_W  = 5,
  parameter int DATA_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [1:0]         laneMode,
  input  logic [ADDR_W-1:0]  addrBytes,
  input  logic [DUMMY_W-1:0] dummyClocks,
  input  logic [DATA_W-1:0]  dataBytes,
  input  logic               isRead,
  output logic               busy,
  output logic               done,
  output logic               csN,
  output logic               sclk,
  output logic [3:0]         ioOe,
  output logic               txTake,
  output strobe_t            strb
);
  localparam int CNT_A = (ADDR_W > DUMMY_W) ? ADDR_W : DUMMY_W;
  localparam int CNT_W = (CNT_A > DATA_W) ? CNT_A : DATA_W;
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  phase_e             phase, nxt, succ;
  lane_e              modeR, curWidth;
  logic [DIV_W-1:0]   divCnt;
  logic [CNT_W-1:0]   unitLeft, nxtUnits;
  logic [2:0]         beatLeft, byteBeatsM1, nxtBeats;
  logic [ADDR_W-1:0]  addrR;
  logic [DUMMY_W-1:0] dummyR;
  logic [DATA_W-1:0]  dataR;
  logic               readR, tick, rise, fall, unitEnd, lastUnit;
  logic [3:0]         laneMask, dataOe;
  logic               pinsHigh;

  function automatic lane_e toLane(input logic [1:0] m);
    case (m)
      2'd0:    return LW_ONE;
      2'd1:    return LW_TWO;
      default: return LW_FOUR;
    endcase
  endfunction

  assign tick     = (phase != PH_IDLE) && (divCnt == DIV_LAST);
  assign rise     = tick && !sclk && (phase != PH_TAIL);
  assign fall     = tick && sclk;
  assign unitEnd  = fall && (beatLeft == 3'd0);
  assign lastUnit = (unitLeft == CNT_W'(1));
  assign curWidth = (phase == PH_CMD) ? LW_ONE : modeR;

  always_comb begin
    case (modeR)
      LW_ONE:  byteBeatsM1 = 3'd7;
      LW_TWO:  byteBeatsM1 = 3'd3;
      default: byteBeatsM1 = 3'd1;
    endcase
    case (phase)
      PH_CMD:   succ = (addrR != '0) ? PH_ADDR : (dummyR != '0) ? PH_DUMMY
                     : (dataR != '0) ? PH_DATA : PH_TAIL;
      PH_ADDR:  succ = (dummyR != '0) ? PH_DUMMY : (dataR != '0) ? PH_DATA : PH_TAIL;
      PH_DUMMY: succ = (dataR != '0) ? PH_DATA : PH_TAIL;
      default:  succ = PH_TAIL;
    endcase
    nxt = lastUnit ? succ : phase;
    case (nxt)
      PH_ADDR:  nxtUnits = CNT_W'(addrR);
      PH_DUMMY: nxtUnits = CNT_W'(dummyR);
      PH_DATA:  nxtUnits = CNT_W'(dataR);
      default:  nxtUnits = CNT_W'(1);
    endcase
    nxtBeats = (nxt == PH_DUMMY) ? 3'd0 : byteBeatsM1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      done     <= 1'b0;
      divCnt   <= '0;
      unitLeft <= '0;
      beatLeft <= '0;
      modeR    <= LW_ONE;
      addrR    <= '0;
      dummyR   <= '0;
      dataR    <= '0;
      readR    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start) begin
          phase    <= PH_CMD;
          csN      <= 1'b0;
          divCnt   <= '0;
          unitLeft <= CNT_W'(1);
          beatLeft <= 3'd7;
          modeR    <= toLane(laneMode);
          addrR    <= addrBytes;
          dummyR   <= dummyClocks;
          dataR    <= dataBytes;
          readR    <= isRead;
        end
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (phase == PH_TAIL) begin
          if (tick) begin
            csN   <= 1'b1;
            done  <= 1'b1;
            phase <= PH_IDLE;
          end
        end else if (rise) begin
          sclk <= 1'b1;
        end else if (fall) begin
          sclk <= 1'b0;
          if (beatLeft != 3'd0) begin
            beatLeft <= beatLeft - 3'd1;
          end else begin
            phase    <= nxt;
            unitLeft <= lastUnit ? nxtUnits : unitLeft - 1'b1;
            beatLeft <= nxtBeats;
          end
        end
      end
    end
  end

  always_comb begin
    strb.loadCmd = (phase == PH_IDLE) && start;
    strb.sample  = rise;
    strb.shift   = fall;
    strb.loadTx  = unitEnd && ((nxt == PH_ADDR) || ((nxt == PH_DATA) && !readR));
    strb.rxPush  = unitEnd && (phase == PH_DATA) && readR;
    strb.width   = curWidth;
  end
  assign txTake = strb.loadTx;
  assign busy   = (phase != PH_IDLE);

  always_comb begin
    case (modeR)
      LW_ONE:  laneMask = 4'b0001;
      LW_TWO:  laneMask = 4'b0011;
      default: laneMask = 4'b1111;
    endcase
    case (phase)
      PH_CMD:  dataOe = 4'b0001;
      PH_ADDR: dataOe = laneMask;
      PH_DATA: dataOe = readR ? 4'b0000 : laneMask;
      default: dataOe = 4'b0000;
    endcase
    pinsHigh = (phase != PH_IDLE) && ((modeR != LW_FOUR) || (phase == PH_CMD));
    ioOe = dataOe | (pinsHigh ? 4'b1100 : 4'b0000);
  end

  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_cs_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && $past(!csN)));
  assert_oe_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (ioOe == 4'b0000));

  generate
    if (HALF_DIV > 1) begin : gHold
      assert_sclk_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
        $rose(sclk) |=> sclk);
    end
  endgenerate
endmodule

// File: rtl/mlane_spi_datapath.sv
module mlane_spi_datapath
  import mlaneSpiPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strb,
  input  logic [7:0] cmdByte,
  input  logic [7:0] txData,
  input  logic [3:0] ioIn,
  output logic [3:0] ioOut,
  output logic [7:0] rxData,
  output logic       rxValid
);
  logic [7:0] sr, shifted;
  logic [3:0] inBits;

  always_comb begin
    case (strb.width)
      LW_ONE:  shifted = {sr[6:0], inBits[0]};
      LW_TWO:  shifted = {sr[5:0], inBits[1:0]};
      default: shifted = {sr[3:0], inBits[3:0]};
    endcase
    case (strb.width)
      LW_ONE:  ioOut = {2'b11, 1'b0, sr[7]};
      LW_TWO:  ioOut = {2'b11, sr[7:6]};
      default: ioOut = sr[7:4];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sr      <= '0;
      inBits  <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strb.rxPush;
      if (strb.loadCmd)     sr <= cmdByte;
      else if (strb.loadTx) sr <= txData;
      else if (strb.shift)  sr <= shifted;
      if (strb.sample) begin
        case (strb.width)
          LW_ONE:  inBits <= {3'b000, ioIn[1]};
          LW_TWO:  inBits <= {2'b00, ioIn[1:0]};
          default: inBits <= ioIn;
        endcase
      end
      if (strb.rxPush) rxData <= shifted;
    end
  end

  assert_load_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadCmd && strb.loadTx));
  assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/mlane_spi_shifter.sv
module mlane_spi_shifter
  import mlaneSpiPkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 3,
  parameter int DUMMY_W  = 5,
  parameter int DATA_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [7:0]         cmdByte,
  input  logic [1:0]         laneMode,
  input  logic [ADDR_W-1:0]  addrBytes,
  input  logic [DUMMY_W-1:0] dummyClocks,
  input  logic [DATA_W-1:0]  dataBytes,
  input  logic               isRead,
  input  logic [7:0]         txData,
  output logic               txTake,
  output logic [7:0]         rxData,
  output logic               rxValid,
  output logic               busy,
  output logic               done,
  output logic               csN,
  output logic               sclk,
  output logic [3:0]         ioOut,
  output logic [3:0]         ioOe,
  input  logic [3:0]         ioIn
);
  strobe_t strb;

  mlane_spi_ctrl #(
    .HALF_DIV(HALF_DIV), .ADDR_W(ADDR_W), .DUMMY_W(DUMMY_W), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .laneMode(laneMode),
    .addrBytes(addrBytes), .dummyClocks(dummyClocks), .dataBytes(dataBytes),
    .isRead(isRead), .busy(busy), .done(done), .csN(csN), .sclk(sclk),
    .ioOe(ioOe), .txTake(txTake), .strb(strb)
  );

  mlane_spi_datapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdByte(cmdByte), .txData(txData),
    .ioIn(ioIn), .ioOut(ioOut), .rxData(rxData), .rxValid(rxValid)
  );

  assert_rx_in_txn_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !csN);
endmodule

// File: tb/mlane_spi_shifter_tb_top.sv
module mlane_spi_shifter_tb_top;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, start, isRead, txTake, rxValid, busy, done, csN, sclk;
  logic [7:0] cmdByte, txData, rxData;
  logic [1:0] laneMode;
  logic [2:0] addrBytes;
  logic [4:0] dummyClocks;
  logic [7:0] dataBytes;
  logic [3:0] ioOut, ioOe, ioIn;

  mlane_spi_shifter #(.HALF_DIV(HALF_DIV)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cmdByte(cmdByte), .laneMode(laneMode),
    .addrBytes(addrBytes), .dummyClocks(dummyClocks), .dataBytes(dataBytes),
    .isRead(isRead), .txData(txData), .txTake(txTake), .rxData(rxData),
    .rxValid(rxValid), .busy(busy), .done(done), .csN(csN), .sclk(sclk),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] txMem[16];
  logic [7:0] rxExp[16];
  int cfgW, cfgAddr, cfgDummy, cfgData;
  bit cfgRead;
  logic [7:0] cfgCmd;
  int fallCnt, rxIdx, txIdx, takeCnt, doneCnt, edgeCyc;
  bit takePend = 0, sclkPrev = 0, csPrev = 1;

  assign txData = txMem[txIdx % 16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int bpb();
    return 8 / cfgW;
  endfunction

  function automatic void phaseOf(input int b, output int ph, output int off);
    int r = b;
    off = 0;
    if (r < 8) begin ph = 0; off = r; return; end
    r -= 8;
    if (r < cfgAddr * bpb()) begin ph = 1; off = r; return; end
    r -= cfgAddr * bpb();
    if (r < cfgDummy) begin ph = 2; off = r; return; end
    r -= cfgDummy;
    if (r < cfgData * bpb()) begin ph = 3; off = r; return; end
    ph = 4;
  endfunction

  function automatic int totalBeats();
    return 8 + cfgAddr * bpb() + cfgDummy + cfgData * bpb();
  endfunction

  function automatic int expOe(input int b);
    int ph, off, lanes, dataOe;
    phaseOf(b, ph, off);
    lanes = (1 << cfgW) - 1;
    if (ph == 0) dataOe = 1;
    else if (ph == 1 || (ph == 3 && !cfgRead)) dataOe = lanes;
    else dataOe = 0;
    return dataOe | (((cfgW != 4) || (ph == 0)) ? 12 : 0);
  endfunction

  function automatic int groupOf(input logic [7:0] v, input int k);
    return (int'(v) >> (8 - cfgW * (k + 1))) & ((1 << cfgW) - 1);
  endfunction

  function automatic logic [3:0] readBits(input int b);
    int ph, off, val;
    phaseOf(b, ph, off);
    if (ph != 3 || !cfgRead) return 4'h0;
    val = groupOf(rxExp[off / bpb()], off % bpb());
    return (cfgW == 1) ? 4'(val << 1) : 4'(val);
  endfunction

  always @(negedge clk) begin
    int ph, off, e;
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (takePend) begin txIdx++; takePend = 0; end
    if (txTake) begin takePend = 1; takeCnt++; end
    if (!csN) begin
      if (csPrev) begin edgeCyc = cyc; fallCnt = 0; end
      if (sclk && !sclkPrev) begin
        chk(cyc - edgeCyc == HALF_DIV, "R9 half period", cyc - edgeCyc, HALF_DIV);
        edgeCyc = cyc;
        phaseOf(fallCnt, ph, off);
        if (ph == 0)
          chk(ioOut[0] == cfgCmd[7 - off], "R2 command bit", ioOut[0], cfgCmd[7 - off]);
        else if (ph == 1) begin
          e = groupOf(txMem[off / bpb()], off % bpb());
          chk((ioOut & 4'((1 << cfgW) - 1)) == e, "R3 address group",
              ioOut & 4'((1 << cfgW) - 1), e);
        end else if (ph == 3 && !cfgRead) begin
          e = groupOf(txMem[cfgAddr + off / bpb()], off % bpb());
          chk((ioOut & 4'((1 << cfgW) - 1)) == e, "R3 write group",
              ioOut & 4'((1 << cfgW) - 1), e);
        end
      end
      if (!sclk && sclkPrev) begin
        chk(cyc - edgeCyc == HALF_DIV, "R9 half period", cyc - edgeCyc, HALF_DIV);
        edgeCyc = cyc;
        fallCnt++;
      end
      e = expOe(fallCnt);
      chk(ioOe == 4'(e), "R5 R6 output enables", ioOe, e);
      if (e >= 12 && ((cfgW != 4) || fallCnt < 8))
        chk(ioOut[3:2] == 2'b11, "R7 protect/hold high", ioOut[3:2], 3);
      ioIn = readBits(fallCnt);
    end else begin
      if (!csPrev)
        chk(cyc - edgeCyc == HALF_DIV, "R8 cs rise delay", cyc - edgeCyc, HALF_DIV);
      chk(ioOe == 4'h0 && !sclk, "R1 idle bus", {ioOe, 3'b000, sclk}, 0);
    end
    if (rxValid) begin
      chk(cfgRead && rxData == rxExp[rxIdx % 16], "R4 read byte", rxData, rxExp[rxIdx % 16]);
      rxIdx++;
    end
    if (done) begin
      doneCnt++;
      chk(csN == 1'b1, "R8 cs high at done", csN, 1);
      chk(fallCnt == totalBeats(), "R5 SCLK count", fallCnt, totalBeats());
      chk(rxIdx == (cfgRead ? cfgData : 0), "R4 read byte count", rxIdx,
          cfgRead ? cfgData : 0);
      chk(takeCnt == cfgAddr + (cfgRead ? 0 : cfgData), "R10 take count", takeCnt,
          cfgAddr + (cfgRead ? 0 : cfgData));
    end
    sclkPrev = sclk;
    csPrev = csN;
  end

  task automatic runTxn(input logic [7:0] cmd, input int mode, input int na,
                        input int nd, input int nb, input bit rd, input int seed);
    int waitCnt;
    for (int i = 0; i < 16; i++) begin
      txMem[i] = 8'((i * 37 + seed * 11) ^ 8'h5A);
      rxExp[i] = 8'((i * 53 + seed * 7) ^ 8'hC3);
    end
    cfgCmd = cmd; cfgW = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
    cfgAddr = na; cfgDummy = nd; cfgData = nb; cfgRead = rd;
    fallCnt = 0; rxIdx = 0; txIdx = 0; takeCnt = 0; doneCnt = 0;
    cmdByte = cmd; laneMode = 2'(mode); addrBytes = 3'(na);
    dummyClocks = 5'(nd); dataBytes = 8'(nb); isRead = rd;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !csN, "R8 cs low after start", {busy, csN}, 2);
    waitCnt = 0;
    while (doneCnt == 0 && waitCnt < 20000) begin @(negedge clk); waitCnt++; end
    repeat (4) @(negedge clk);
    chk(doneCnt == 1, "R8 single done pulse", doneCnt, 1);
    chk(!busy, "R1 idle after done", busy, 0);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; cmdByte = '0; laneMode = '0; addrBytes = '0;
    dummyClocks = '0; dataBytes = '0; isRead = 1'b0; ioIn = '0;
    cfgW = 1; cfgAddr = 0; cfgDummy = 0; cfgData = 0; cfgRead = 0; cfgCmd = '0;
    for (int i = 0; i < 16; i++) begin txMem[i] = '0; rxExp[i] = '0; end
    repeat (3) @(negedge clk);
    chk(csN && !sclk && ioOe == 0 && !done && !busy, "R1 reset state",
        {csN, sclk, ioOe, done, busy}, 8'h80);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runTxn(8'h02, 0, 2, 0, 2, 0, 1);   // single write
    runTxn(8'h0B, 0, 1, 8, 3, 1, 2);   // single read with dummy
    runTxn(8'h3B, 1, 3, 8, 3, 1, 3);   // dual read
    runTxn(8'hA2, 1, 2, 0, 4, 0, 4);   // dual write
    runTxn(8'h32, 2, 1, 0, 2, 0, 5);   // quad write
    runTxn(8'hEB, 2, 2, 4, 4, 1, 6);   // quad read
    runTxn(8'h6B, 3, 3, 6, 5, 1, 7);   // mode code 3 acts as quad
    runTxn(8'h06, 2, 0, 0, 0, 0, 8);   // command only
    runTxn(8'h9F, 1, 0, 0, 3, 1, 9);   // read straight after command
    runTxn(8'h81, 2, 0, 3, 0, 0, 10);  // dummy clocks only
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule